// File: doc/BRIEF.md
# Four-Slot Instruction Dispatch Router

The router sits between the fetch path and the execution side of a superscalar core. Each cycle it looks at a window of up to four instructions. Instructions held over from the previous cycle come first, followed by the valid slots of the newly fetched group. Each instruction carries a two-bit class code. Branch and condition-register operations go to two internal dispatch ports that feed the branch unit. Fixed-point and floating-point operations go to two external dispatch ports that feed the two execution-unit queues.

The external ports have no pairing rule. Both slots may carry fixed-point work, both may carry floating-point work, or they may carry one of each. A per-port flag tells each port which queue to write. Each queue reports how many entries it can take this cycle, and the branch unit gives a single ready bit. Dispatch is strictly in program order. The first window entry that cannot be placed stops itself and every entry behind it. Entries that are not dispatched stay in a small holding buffer and lead the window on the next cycle.

The fetch side learns how many of its valid slots were absorbed through an accepted-count output. It re-presents the rest later.

Top module: `disp_router`

## Requirements
- R1: After reset the holding buffer is empty. With no valid input, no dispatch port is valid and the accepted count is 0.
- R2: Class 2'b00 (branch/CR) entries go only to the internal ports, and only when the branch unit is ready. They fill port 0 before port 1, and at most two go per cycle.
- R3: Class 2'b01 (fixed-point) and 2'b10 (floating-point) entries go to the external ports, port 0 first. The port's queue flag is 1 for floating-point and 0 for fixed-point. The unused code 2'b11 is routed as fixed-point.
- R4: The two external ports take any mix in one cycle: two floating-point, two fixed-point, or one of each.
- R5: The number of fixed-point (floating-point) entries dispatched in a cycle never exceeds that queue's free count. A free count of 3 behaves as 2.
- R6: Dispatch is in order. The first window entry that cannot be placed, because of the port limit, the queue space or branch readiness, holds itself and all later entries.
- R7: Invalid input slots are ignored. Valid slots enter the window in slot order (slot 0 first), directly behind any held entries.
- R8: Undispatched entries are presented again at the front of the next cycle's window, in their original order. The accepted count equals the number of valid input slots that fit into the four-entry window behind the held entries.
- R9: The dispatch ports reflect the current window in the same cycle the group is presented, with no added register stage.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| grp_vld_i | input | SLOTS | Per-slot valid of the fetched group |
| grp_cls_i | input | 2*SLOTS | Per-slot class code, slot j at bits [2j+1:2j] |
| grp_ins_i | input | SLOTS*DATA_W | Per-slot instruction word |
| grp_take_o | output | clog2(SLOTS+1) | Number of valid input slots absorbed this cycle |
| br_rdy_i | input | 1 | Branch unit can accept this cycle |
| fx_free_i | input | clog2(EXT_P+1) | Fixed-point queue free entries |
| fp_free_i | input | clog2(EXT_P+1) | Floating-point queue free entries |
| int_vld_o | output | INT_P | Internal dispatch port valid |
| int_ins_o | output | INT_P*DATA_W | Internal dispatch port instruction |
| ext_vld_o | output | EXT_P | External dispatch port valid |
| ext_fp_o | output | EXT_P | External port targets floating-point queue (1) or fixed-point (0) |
| ext_ins_o | output | EXT_P*DATA_W | External dispatch port instruction |

## Verification
The bench uses the default shape: four slots, two internal and two external ports, and 8-bit instruction words tagged with sequence numbers. The sweep covers every combination of four class codes with every valid mask, 4096 groups in all. Branch readiness and both queue free counts, including the saturating value 3, rotate underneath the sweep. As a result, the held buffer reaches every fill level and every blocking position in the window. Each external pairing and each hole pattern in the valid mask also occurs.

// File: rtl/disp_pkg.sv
package disp_pkg;
  typedef enum logic [1:0] {
    CLS_BR  = 2'b00,
    CLS_FX  = 2'b01,
    CLS_FP  = 2'b10,
    CLS_RSV = 2'b11
  } cls_e;
endpackage

// File: rtl/disp_merge.sv
module disp_merge #(
  parameter int SLOTS  = 4,
  parameter int DATA_W = 32,
  localparam int CW    = $clog2(SLOTS + 1),
  localparam int IW    = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic [CW-1:0]                 hold_cnt_i,
  input  logic [SLOTS-1:0][1:0]         hold_cls_i,
  input  logic [SLOTS-1:0][DATA_W-1:0]  hold_ins_i,
  input  logic [SLOTS-1:0]              grp_vld_i,
  input  logic [SLOTS-1:0][1:0]         grp_cls_i,
  input  logic [SLOTS-1:0][DATA_W-1:0]  grp_ins_i,
  output logic [SLOTS-1:0]              win_vld_o,
  output logic [SLOTS-1:0][1:0]         win_cls_o,
  output logic [SLOTS-1:0][DATA_W-1:0]  win_ins_o,
  output logic [CW-1:0]                 take_o
);
  logic [CW-1:0] rank;
  logic [CW-1:0] take;

  always_comb begin
    win_vld_o = '0;
    win_cls_o = '0;
    win_ins_o = '0;
    for (int i = 0; i < SLOTS; i++) begin
      if (CW'(i) < hold_cnt_i) begin
        win_vld_o[i] = 1'b1;
        win_cls_o[i] = hold_cls_i[i];
        win_ins_o[i] = hold_ins_i[i];
      end
    end
    // new valid slots packed behind held entries
    rank = hold_cnt_i;
    take = '0;
    for (int j = 0; j < SLOTS; j++) begin
      if (grp_vld_i[j] && (rank < CW'(SLOTS))) begin
        win_vld_o[rank[IW-1:0]] = 1'b1;
        win_cls_o[rank[IW-1:0]] = grp_cls_i[j];
        win_ins_o[rank[IW-1:0]] = grp_ins_i[j];
        rank = rank + CW'(1);
        take = take + CW'(1);
      end
    end
    take_o = take;
  end
endmodule

// File: rtl/disp_pick.sv
module disp_pick
  import disp_pkg::*;
#(
  parameter int SLOTS  = 4,
  parameter int DATA_W = 32,
  parameter int INT_P  = 2,
  parameter int EXT_P  = 2,
  localparam int CW    = $clog2(SLOTS + 1),
  localparam int FW    = $clog2(EXT_P + 1),
  localparam int NW    = $clog2(SLOTS + INT_P + EXT_P + 4),
  localparam int IPW   = (INT_P > 1) ? $clog2(INT_P) : 1,
  localparam int EPW   = (EXT_P > 1) ? $clog2(EXT_P) : 1
) (
  input  logic [SLOTS-1:0]              win_vld_i,
  input  logic [SLOTS-1:0][1:0]         win_cls_i,
  input  logic [SLOTS-1:0][DATA_W-1:0]  win_ins_i,
  input  logic                          br_rdy_i,
  input  logic [FW-1:0]                 fx_free_i,
  input  logic [FW-1:0]                 fp_free_i,
  output logic [INT_P-1:0]              int_vld_o,
  output logic [INT_P-1:0][DATA_W-1:0]  int_ins_o,
  output logic [EXT_P-1:0]              ext_vld_o,
  output logic [EXT_P-1:0]              ext_fp_o,
  output logic [EXT_P-1:0][DATA_W-1:0]  ext_ins_o,
  output logic [CW-1:0]                 used_o
);
  logic          stop, ok, is_fp;
  logic [NW-1:0] n_int, n_ext, n_fx, n_fp, fx_lim, fp_lim;
  logic [CW-1:0] used;

  always_comb begin
    int_vld_o = '0;
    int_ins_o = '0;
    ext_vld_o = '0;
    ext_fp_o  = '0;
    ext_ins_o = '0;
    stop  = 1'b0;
    ok    = 1'b0;
    is_fp = 1'b0;
    n_int = '0;
    n_ext = '0;
    n_fx  = '0;
    n_fp  = '0;
    used  = '0;
    fx_lim = NW'(fx_free_i);
    fp_lim = NW'(fp_free_i);
    for (int i = 0; i < SLOTS; i++) begin
      ok    = 1'b0;
      is_fp = (win_cls_i[i] == CLS_FP);
      if (win_vld_i[i] && !stop) begin
        case (cls_e'(win_cls_i[i]))
          CLS_BR:  ok = br_rdy_i && (n_int < NW'(INT_P));
          CLS_FP:  ok = (n_ext < NW'(EXT_P)) && (n_fp < fp_lim);
          default: ok = (n_ext < NW'(EXT_P)) && (n_fx < fx_lim);
        endcase
        if (!ok) begin
          stop = 1'b1;
        end else if (win_cls_i[i] == CLS_BR) begin
          int_vld_o[n_int[IPW-1:0]] = 1'b1;
          int_ins_o[n_int[IPW-1:0]] = win_ins_i[i];
          n_int = n_int + NW'(1);
        end else begin
          ext_vld_o[n_ext[EPW-1:0]] = 1'b1;
          ext_fp_o[n_ext[EPW-1:0]]  = is_fp;
          ext_ins_o[n_ext[EPW-1:0]] = win_ins_i[i];
          n_ext = n_ext + NW'(1);
          if (is_fp) n_fp = n_fp + NW'(1);
          else       n_fx = n_fx + NW'(1);
        end
        if (ok) used = used + CW'(1);
      end
    end
    used_o = used;
  end
endmodule

// File: rtl/disp_hold.sv
module disp_hold #(
  parameter int SLOTS  = 4,
  parameter int DATA_W = 32,
  localparam int CW    = $clog2(SLOTS + 1),
  localparam int XW    = CW + 1,
  localparam int IW    = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [SLOTS-1:0]              win_vld_i,
  input  logic [SLOTS-1:0][1:0]         win_cls_i,
  input  logic [SLOTS-1:0][DATA_W-1:0]  win_ins_i,
  input  logic [CW-1:0]                 used_i,
  output logic [CW-1:0]                 hold_cnt_o,
  output logic [SLOTS-1:0][1:0]         hold_cls_o,
  output logic [SLOTS-1:0][DATA_W-1:0]  hold_ins_o
);
  logic [CW-1:0]                cnt_nxt;
  logic [SLOTS-1:0][1:0]        cls_nxt;
  logic [SLOTS-1:0][DATA_W-1:0] ins_nxt;
  logic [XW-1:0]                idx;

  always_comb begin
    cls_nxt = '0;
    ins_nxt = '0;
    idx     = '0;
    // shift out dispatched prefix
    for (int i = 0; i < SLOTS; i++) begin
      idx = XW'(i) + {1'b0, used_i};
      if (idx < XW'(SLOTS)) begin
        cls_nxt[i] = win_cls_i[idx[IW-1:0]];
        ins_nxt[i] = win_ins_i[idx[IW-1:0]];
      end
    end
    cnt_nxt = CW'($countones(win_vld_i)) - used_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_cnt_o <= '0;
      hold_cls_o <= '0;
      hold_ins_o <= '0;
    end else begin
      hold_cnt_o <= cnt_nxt;
      hold_cls_o <= cls_nxt;
      hold_ins_o <= ins_nxt;
    end
  end
endmodule

// File: rtl/disp_router.sv
module disp_router #(
  parameter int SLOTS  = 4,
  parameter int DATA_W = 32,
  parameter int INT_P  = 2,
  parameter int EXT_P  = 2,
  localparam int CW    = $clog2(SLOTS + 1),
  localparam int FW    = $clog2(EXT_P + 1)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [SLOTS-1:0]           grp_vld_i,
  input  logic [2*SLOTS-1:0]         grp_cls_i,
  input  logic [SLOTS*DATA_W-1:0]    grp_ins_i,
  output logic [CW-1:0]              grp_take_o,
  input  logic                       br_rdy_i,
  input  logic [FW-1:0]              fx_free_i,
  input  logic [FW-1:0]              fp_free_i,
  output logic [INT_P-1:0]           int_vld_o,
  output logic [INT_P*DATA_W-1:0]    int_ins_o,
  output logic [EXT_P-1:0]           ext_vld_o,
  output logic [EXT_P-1:0]           ext_fp_o,
  output logic [EXT_P*DATA_W-1:0]    ext_ins_o
);
  logic [CW-1:0]                hold_cnt;
  logic [SLOTS-1:0][1:0]        hold_cls;
  logic [SLOTS-1:0][DATA_W-1:0] hold_ins;
  logic [SLOTS-1:0]             win_vld;
  logic [SLOTS-1:0][1:0]        win_cls;
  logic [SLOTS-1:0][DATA_W-1:0] win_ins;
  logic [CW-1:0]                used;
  logic [INT_P-1:0][DATA_W-1:0] int_ins;
  logic [EXT_P-1:0][DATA_W-1:0] ext_ins;

  disp_merge #(.SLOTS(SLOTS), .DATA_W(DATA_W)) u_merge (
    .hold_cnt_i (hold_cnt),
    .hold_cls_i (hold_cls),
    .hold_ins_i (hold_ins),
    .grp_vld_i  (grp_vld_i),
    .grp_cls_i  (grp_cls_i),
    .grp_ins_i  (grp_ins_i),
    .win_vld_o  (win_vld),
    .win_cls_o  (win_cls),
    .win_ins_o  (win_ins),
    .take_o     (grp_take_o)
  );

  disp_pick #(.SLOTS(SLOTS), .DATA_W(DATA_W), .INT_P(INT_P), .EXT_P(EXT_P)) u_pick (
    .win_vld_i (win_vld),
    .win_cls_i (win_cls),
    .win_ins_i (win_ins),
    .br_rdy_i  (br_rdy_i),
    .fx_free_i (fx_free_i),
    .fp_free_i (fp_free_i),
    .int_vld_o (int_vld_o),
    .int_ins_o (int_ins),
    .ext_vld_o (ext_vld_o),
    .ext_fp_o  (ext_fp_o),
    .ext_ins_o (ext_ins),
    .used_o    (used)
  );

  disp_hold #(.SLOTS(SLOTS), .DATA_W(DATA_W)) u_hold (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .win_vld_i  (win_vld),
    .win_cls_i  (win_cls),
    .win_ins_i  (win_ins),
    .used_i     (used),
    .hold_cnt_o (hold_cnt),
    .hold_cls_o (hold_cls),
    .hold_ins_o (hold_ins)
  );

  assign int_ins_o = int_ins;
  assign ext_ins_o = ext_ins;
endmodule

// File: rtl/disp_router_chk.sv
module disp_router_chk #(
  parameter int SLOTS  = 4,
  parameter int INT_P  = 2,
  parameter int EXT_P  = 2,
  localparam int CW    = $clog2(SLOTS + 1),
  localparam int FW    = $clog2(EXT_P + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [SLOTS-1:0] grp_vld_i,
  input logic [CW-1:0]    grp_take_o,
  input logic             br_rdy_i,
  input logic [FW-1:0]    fx_free_i,
  input logic [FW-1:0]    fp_free_i,
  input logic [INT_P-1:0] int_vld_o,
  input logic [EXT_P-1:0] ext_vld_o,
  input logic [EXT_P-1:0] ext_fp_o
);
  p_int_gate_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !br_rdy_i |-> (int_vld_o == '0));

  p_int_fill_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_vld_o[INT_P-1] |-> int_vld_o[0]);

  p_ext_fill_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_vld_o[EXT_P-1] |-> ext_vld_o[0]);

  p_fp_flag_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ext_fp_o & ~ext_vld_o) == '0);

  p_fx_limit_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(ext_vld_o & ~ext_fp_o) <= int'(fx_free_i));

  p_fp_limit_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(ext_vld_o & ext_fp_o) <= int'(fp_free_i));

  p_take_bound_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(grp_take_o) <= $countones(grp_vld_i));
endmodule

bind disp_router disp_router_chk #(.SLOTS(SLOTS), .INT_P(INT_P), .EXT_P(EXT_P)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .grp_vld_i  (grp_vld_i),
  .grp_take_o (grp_take_o),
  .br_rdy_i   (br_rdy_i),
  .fx_free_i  (fx_free_i),
  .fp_free_i  (fp_free_i),
  .int_vld_o  (int_vld_o),
  .ext_vld_o  (ext_vld_o),
  .ext_fp_o   (ext_fp_o)
);

// File: tb/disp_router_bench.sv
module disp_router_bench;
  localparam int CLK_PERIOD = 10;
  localparam int SLOTS = 4;
  localparam int DW    = 8;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic [3:0]       grp_vld_i = '0;
  logic [7:0]       grp_cls_i = '0;
  logic [31:0]      grp_ins_i = '0;
  logic [2:0]       grp_take_o;
  logic             br_rdy_i = 1'b0;
  logic [1:0]       fx_free_i = '0;
  logic [1:0]       fp_free_i = '0;
  logic [1:0]       int_vld_o;
  logic [15:0]      int_ins_o;
  logic [1:0]       ext_vld_o;
  logic [1:0]       ext_fp_o;
  logic [15:0]      ext_ins_o;

  int n_tests = 0;
  int n_fail  = 0;
  int mh_c[8];
  int mh_d[8];
  int mh_n = 0;
  int id = 0;
  int last_id = 0;
  int n2fp = 0, n2fx = 0, nmix = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  disp_router #(.SLOTS(SLOTS), .DATA_W(DW), .INT_P(2), .EXT_P(2)) u_disp_router (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .grp_vld_i(grp_vld_i), .grp_cls_i(grp_cls_i), .grp_ins_i(grp_ins_i),
    .grp_take_o(grp_take_o), .br_rdy_i(br_rdy_i),
    .fx_free_i(fx_free_i), .fp_free_i(fp_free_i),
    .int_vld_o(int_vld_o), .int_ins_o(int_ins_o),
    .ext_vld_o(ext_vld_o), .ext_fp_o(ext_fp_o), .ext_ins_o(ext_ins_o)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // drive one group, compare against the in-order model, advance the model
  task automatic run_cycle(input logic [3:0] v, input logic [7:0] c, input logic b,
                           input logic [1:0] fx, input logic [1:0] fp);
    int wc[8];
    int wd[8];
    int wn, ni, ne, nx, np, used, fxl, fpl, e_take;
    bit stop;
    logic [1:0]  e_iv, e_ev, e_ef;
    logic [15:0] e_id, e_ed;
    @(negedge clk_i);
    grp_vld_i = v;
    grp_cls_i = c;
    for (int j = 0; j < 4; j++) grp_ins_i[j*8 +: 8] = 8'((id + j) & 255);
    br_rdy_i  = b;
    fx_free_i = fx;
    fp_free_i = fp;
    #2;
    wn = mh_n;
    for (int k = 0; k < mh_n; k++) begin wc[k] = mh_c[k]; wd[k] = mh_d[k]; end
    for (int j = 0; j < 4; j++)
      if (v[j] && wn < 4) begin wc[wn] = int'(c[2*j +: 2]); wd[wn] = (id + j) & 255; wn++; end
    e_take = wn - mh_n;
    fxl = (fx > 2) ? 2 : int'(fx);
    fpl = (fp > 2) ? 2 : int'(fp);
    stop = 0; ni = 0; ne = 0; nx = 0; np = 0; used = 0;
    e_iv = '0; e_ev = '0; e_ef = '0; e_id = '0; e_ed = '0;
    for (int k = 0; k < wn; k++) begin
      if (!stop) begin
        if (wc[k] == 0) begin
          if (b && ni < 2) begin
            e_iv[ni] = 1'b1; e_id[ni*8 +: 8] = 8'(wd[k]); ni++; used++;
          end else stop = 1;
        end else if (wc[k] == 2) begin
          if (ne < 2 && np < fpl) begin
            e_ev[ne] = 1'b1; e_ef[ne] = 1'b1; e_ed[ne*8 +: 8] = 8'(wd[k]); ne++; np++; used++;
          end else stop = 1;
        end else begin
          if (ne < 2 && nx < fxl) begin
            e_ev[ne] = 1'b1; e_ed[ne*8 +: 8] = 8'(wd[k]); ne++; nx++; used++;
          end else stop = 1;
        end
      end
    end
    chk(grp_take_o == 3'(e_take), "R8 accepted count", 32'(grp_take_o), 32'(e_take));
    chk({int_vld_o, int_ins_o} == {e_iv, e_id}, "R2 internal ports",
        32'({int_vld_o, int_ins_o}), 32'({e_iv, e_id}));
    chk({ext_vld_o, ext_fp_o} == {e_ev, e_ef}, "R3 R5 external routing",
        32'({ext_vld_o, ext_fp_o}), 32'({e_ev, e_ef}));
    chk(ext_ins_o == e_ed, "R6 R7 order on external ports", 32'(ext_ins_o), 32'(e_ed));
    if (e_ev == 2'b11) begin
      if (e_ef == 2'b11) n2fp++;
      else if (e_ef == 2'b00) n2fx++;
      else nmix++;
    end
    mh_n = wn - used;
    for (int k = 0; k < mh_n; k++) begin mh_c[k] = wc[k + used]; mh_d[k] = wd[k + used]; end
    last_id = id;
    id = id + 4;
  endtask

  task automatic drain();
    for (int k = 0; k < 3; k++) run_cycle(4'b0000, 8'h00, 1'b1, 2'd2, 2'd2);
  endtask

  initial begin
    repeat (50000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
    #1;
    // R1: idle after reset
    chk({int_vld_o, ext_vld_o, grp_take_o} == '0, "R1 idle after reset",
        32'({int_vld_o, ext_vld_o, grp_take_o}), 0);
    run_cycle(4'b0000, 8'h00, 1'b1, 2'd2, 2'd2);

    // R9: same-cycle dispatch of a branch
    run_cycle(4'b0001, 8'b00_00_00_00, 1'b1, 2'd2, 2'd2);
    chk(int_vld_o == 2'b01 && int_ins_o[7:0] == 8'(last_id), "R9 same-cycle output",
        32'({int_vld_o, int_ins_o[7:0]}), 32'({2'b01, 8'(last_id)}));
    drain();

    // R7: holes in the valid mask
    run_cycle(4'b1010, 8'b10_00_01_00, 1'b1, 2'd2, 2'd2);
    chk(grp_take_o == 3'd2 && ext_ins_o == {8'(last_id + 3), 8'(last_id + 1)} && ext_fp_o == 2'b10,
        "R7 valid slots packed in slot order", 32'({grp_take_o, ext_fp_o, ext_ins_o}),
        32'({3'd2, 2'b10, 8'(last_id + 3), 8'(last_id + 1)}));
    drain();

    // R3: unused code routes as fixed-point
    run_cycle(4'b0001, 8'b00_00_00_11, 1'b1, 2'd1, 2'd0);
    chk(ext_vld_o == 2'b01 && ext_fp_o == 2'b00, "R3 code 11 as fixed-point",
        32'({ext_vld_o, ext_fp_o}), 32'({2'b01, 2'b00}));
    drain();

    // R5: free count 3 behaves as 2
    run_cycle(4'b1111, 8'b01_01_01_01, 1'b1, 2'd3, 2'd0);
    chk(ext_vld_o == 2'b11 && ext_fp_o == 2'b00, "R5 saturating free count",
        32'({ext_vld_o, ext_fp_o}), 32'({2'b11, 2'b00}));
    run_cycle(4'b0000, 8'h00, 1'b1, 2'd1, 2'd0);
    chk(ext_vld_o == 2'b01, "R5 single free entry", 32'(ext_vld_o), 32'(2'b01));
    drain();

    // R6: a blocked FP holds the branches behind it
    run_cycle(4'b1111, 8'b00_00_10_00, 1'b1, 2'd2, 2'd0);
    chk(int_vld_o == 2'b01 && ext_vld_o == 2'b00, "R6 in-order stall",
        32'({int_vld_o, ext_vld_o}), 32'({2'b01, 2'b00}));
    // R8: held entries lead the next window
    run_cycle(4'b1111, 8'b00_00_00_00, 1'b1, 2'd2, 2'd2);
    chk(grp_take_o == 3'd1 && ext_ins_o[7:0] == 8'(last_id - 3) && int_ins_o == {8'(last_id - 1), 8'(last_id - 2)},
        "R8 held entries first", 32'({grp_take_o, ext_ins_o[7:0], int_ins_o}),
        32'({3'd1, 8'(last_id - 3), 8'(last_id - 1), 8'(last_id - 2)}));
    drain();

    // sweep all class codes x valid masks, rotating readiness
    for (int m = 0; m < 4096; m++) begin
      run_cycle(4'(m >> 8), 8'(m), 1'((m % 3) != 0), 2'(m % 4), 2'((m / 5) % 4));
    end
    drain();

    chk(n2fp > 0, "R4 two floating-point in one cycle", 32'(n2fp), 1);
    chk(n2fx > 0, "R4 two fixed-point in one cycle", 32'(n2fx), 1);
    chk(nmix > 0, "R4 mixed pair in one cycle", 32'(nmix), 1);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule